// File: doc/BRIEF.md
# Profile-Modulated DDS Core

This block is the numerically controlled oscillator datapath of a direct digital synthesizer. On every system clock a 32-bit phase accumulator advances by a frequency tuning word. The top 14 bits of the accumulator are offset by a 14-bit phase word and turned into a signed 10-bit sine sample. That sample is then scaled by a 10-bit amplitude word, and the result is presented as a signed word for a DAC.

Sixteen frequency, phase and amplitude words arrive on flattened parallel buses. A 4-bit profile selector picks one of the sixteen slots, and a 2-bit modulation mode chooses which of the three parameters follows the selector; the other two parameters stay on slot 0. Together these give 16-level FSK, PSK or ASK with no separate strobe. The selector and mode are captured only once per sync-clock period. The sync clock runs at a quarter of the system rate and is driven out so that the source of the selector can align to it. A new selection reaches the output after the same number of cycles whichever parameter it changes.

Top module: `dds_core`

## Requirements
- R1: While `rst` is high, `dac_word` reads 0 and `sync_clk` reads 1. Reset clears the accumulator, selects profile 0 and mode none.
- R2: `sync_clk` is the system clock divided by four: high for two cycles, then low for two. It rises on exactly the edges where the profile and mode are captured.
- R3: `profile_sel` and `mod_mode` are captured only on the edge where `sync_clk` rises. Values that are present only between such edges, and changes to them, have no effect on `dac_word`.
- R4: In frequency mode, the accumulator adds the selected 32-bit tuning word on every system clock and wraps modulo 2^32. When the selected word is zero, the accumulator holds its value.
- R5: The sine phase is the top 14 accumulator bits plus the selected 14-bit phase word, modulo 2^14. Phase 4096 is a quarter turn.
- R6: `dac_word` equals 511·sin(2π·phase/16384)·A/1024 within ±3 LSB, where A is the selected 10-bit amplitude word.
- R7: Mode encoding is 00 none, 01 frequency, 10 phase and 11 amplitude. In mode 00 all three parameters use slot 0. In the other modes, only the named parameter follows the profile and the other two use slot 0.
- R8: A change of the captured profile reaches `dac_word` exactly 4 system clocks after the capture edge, for a frequency, phase or amplitude change alike.
- R9: Profile index k selects bits [k·W +: W] of each bank, where W is 32 for frequency, 14 for phase and 10 for amplitude.
- R10: When the selected amplitude word is zero, `dac_word` is exactly 0 four cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| profile_sel | input | 4 | Profile slot index, sampled at sync-clock rise |
| mod_mode | input | 2 | Modulation target: 00 none, 01 freq, 10 phase, 11 amp |
| ftw_bank | input | 512 | Sixteen 32-bit tuning words, slot k at [32k +: 32] |
| pow_bank | input | 224 | Sixteen 14-bit phase words, slot k at [14k +: 14] |
| asf_bank | input | 160 | Sixteen 10-bit amplitude words, slot k at [10k +: 10] |
| dac_word | output | 10 | Signed scaled sine sample |
| sync_clk | output | 1 | System clock divided by four |

## Verification
The assertions assume that reset is held for at least one edge before any check starts. They also assume that every bank input and the selector are known values, never X, from the first clock on. The bench meets this by loading every bank slot and driving the selector and mode before reset is released. It changes inputs only on falling edges, and it gives the selector random values on arbitrary cycles, so that values which never meet a capture edge are exercised too. The output comparison allows a few LSB for the sine approximation, but the latency and zero-amplitude cases are checked exactly.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int FTW_W  = 32;
    localparam int POW_W  = 14;
    localparam int ASF_W  = 10;
    localparam int SMP_W  = 10;
    localparam int PSEL_W = 4;
    localparam int NPROF  = 1 << PSEL_W;
    localparam int DIV_W  = 2;

    typedef enum logic [1:0] {
        MOD_NONE  = 2'b00,
        MOD_FREQ  = 2'b01,
        MOD_PHASE = 2'b10,
        MOD_AMP   = 2'b11
    } mod_mode_e;

endpackage

// File: rtl/dds_sync_div.sv
module dds_sync_div #(
    parameter int DIV_W = dds_pkg::DIV_W
) (
    input  logic clk,
    input  logic rst,
    output logic load_o,
    output logic sync_clk_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign load_o     = &st_q.cnt;
    assign sync_clk_o = ~st_q.cnt[DIV_W-1];

    // R2
    sync_rise_on_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_clk_o) |-> $past(load_o));

    // R2
    sync_high_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_clk_o) |=> sync_clk_o);

endmodule

// File: rtl/dds_profile_sel.sv
module dds_profile_sel
    import dds_pkg::*;
#(
    parameter int N_PROF = dds_pkg::NPROF,
    parameter int SEL_W  = dds_pkg::PSEL_W,
    parameter int F_W    = dds_pkg::FTW_W,
    parameter int P_W    = dds_pkg::POW_W,
    parameter int A_W    = dds_pkg::ASF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [SEL_W-1:0]    prof_i,
    input  logic [1:0]          mode_i,
    input  logic [N_PROF*F_W-1:0] ftw_bank_i,
    input  logic [N_PROF*P_W-1:0] pow_bank_i,
    input  logic [N_PROF*A_W-1:0] asf_bank_i,
    output logic [F_W-1:0]      ftw_o,
    output logic [P_W-1:0]      pow_o,
    output logic [A_W-1:0]      asf_o
);

    typedef struct packed {
        logic [SEL_W-1:0] idx;
        mod_mode_e        mode;
    } sel_st_t;

    sel_st_t st_d, st_q;
    logic [SEL_W-1:0] f_idx, p_idx, a_idx;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.idx  = prof_i;
            st_d.mode = mod_mode_e'(mode_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.idx  <= '0;
            st_q.mode <= MOD_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        f_idx = (st_q.mode == MOD_FREQ)  ? st_q.idx : '0;
        p_idx = (st_q.mode == MOD_PHASE) ? st_q.idx : '0;
        a_idx = (st_q.mode == MOD_AMP)   ? st_q.idx : '0;
        ftw_o = ftw_bank_i[f_idx*F_W +: F_W];
        pow_o = pow_bank_i[p_idx*P_W +: P_W];
        asf_o = asf_bank_i[a_idx*A_W +: A_W];
    end

    // R3
    hold_between_loads_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(st_q));

endmodule

// File: rtl/dds_sine_eval.sv
module dds_sine_eval #(
    parameter int PH_W = dds_pkg::POW_W,
    parameter int S_W  = dds_pkg::SMP_W
) (
    input  logic [PH_W-1:0]       phase_i,
    output logic signed [S_W-1:0] sample_o
);

    localparam int HALF_W = PH_W - 1;
    localparam int U_W    = 2 * HALF_W + 1;
    localparam int MAG_W  = S_W - 1;
    localparam int PEAK   = (1 << MAG_W) - 1;
    localparam int NUM_W  = U_W + S_W + 4;
    localparam logic [HALF_W:0]  HALF_SPAN = (HALF_W+1)'(1) << HALF_W;
    localparam logic [NUM_W-1:0] DEN_K     = NUM_W'(5) << (2 * HALF_W);
    localparam logic [NUM_W-1:0] NUM_K     = NUM_W'(PEAK * 16);

    logic                 neg;
    logic [HALF_W-1:0]    pos;
    logic [HALF_W:0]      rem;
    logic [U_W-1:0]       u;
    logic [NUM_W-1:0]     num, den, quo;
    logic [MAG_W-1:0]     mag;
    logic signed [S_W-1:0] mag_s;

    // Half-wave rational approximation: sin(pi*x) ~ 16x(1-x) / (5 - 4x(1-x))
    always_comb begin
        neg   = phase_i[PH_W-1];
        pos   = phase_i[HALF_W-1:0];
        rem   = HALF_SPAN - {1'b0, pos};
        u     = U_W'(pos) * U_W'(rem);
        num   = NUM_W'(u) * NUM_K;
        den   = DEN_K - (NUM_W'(u) << 2);
        quo   = num / den;
        mag   = (quo > NUM_W'(PEAK)) ? MAG_W'(PEAK) : quo[MAG_W-1:0];
        mag_s = {1'b0, mag};
        sample_o = neg ? -mag_s : mag_s;
    end

endmodule

// File: rtl/dds_core.sv
module dds_core
    import dds_pkg::*;
#(
    parameter int N_PROF = dds_pkg::NPROF,
    parameter int SEL_W  = dds_pkg::PSEL_W,
    parameter int F_W    = dds_pkg::FTW_W,
    parameter int P_W    = dds_pkg::POW_W,
    parameter int A_W    = dds_pkg::ASF_W,
    parameter int S_W    = dds_pkg::SMP_W,
    parameter int D_W    = dds_pkg::DIV_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SEL_W-1:0]      profile_sel,
    input  logic [1:0]            mod_mode,
    input  logic [N_PROF*F_W-1:0] ftw_bank,
    input  logic [N_PROF*P_W-1:0] pow_bank,
    input  logic [N_PROF*A_W-1:0] asf_bank,
    output logic signed [S_W-1:0] dac_word,
    output logic                  sync_clk
);

    localparam int PROD_W    = S_W + A_W + 1;
    localparam int ALIVE_W   = 3;
    localparam logic [ALIVE_W-1:0] ALIVE_MAX = '1;

    typedef struct packed {
        logic [F_W-1:0]   acc;
        logic [P_W-1:0]   pow1;
        logic [A_W-1:0]   asf1;
        logic [P_W-1:0]   phase;
        logic [A_W-1:0]   asf2;
        logic [S_W-1:0]   sine;
        logic [A_W-1:0]   asf3;
        logic [S_W-1:0]   out;
        logic [ALIVE_W-1:0] alive;
    } core_st_t;

    core_st_t st_d, st_q;

    logic                  load;
    logic [F_W-1:0]        ftw_sel;
    logic [P_W-1:0]        pow_sel;
    logic [A_W-1:0]        asf_sel;
    logic signed [S_W-1:0] sine_val;
    logic signed [PROD_W-1:0] prod;

    dds_sync_div #(.DIV_W(D_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .load_o     (load),
        .sync_clk_o (sync_clk)
    );

    dds_profile_sel #(
        .N_PROF (N_PROF),
        .SEL_W  (SEL_W),
        .F_W    (F_W),
        .P_W    (P_W),
        .A_W    (A_W)
    ) u_sel (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .prof_i     (profile_sel),
        .mode_i     (mod_mode),
        .ftw_bank_i (ftw_bank),
        .pow_bank_i (pow_bank),
        .asf_bank_i (asf_bank),
        .ftw_o      (ftw_sel),
        .pow_o      (pow_sel),
        .asf_o      (asf_sel)
    );

    dds_sine_eval #(.PH_W(P_W), .S_W(S_W)) u_sine (
        .phase_i  (st_q.phase),
        .sample_o (sine_val)
    );

    always_comb begin
        st_d = st_q;
        // stage 1: frequency enters the accumulator, phase and amplitude are registered alongside
        st_d.acc   = st_q.acc + ftw_sel;
        st_d.pow1  = pow_sel;
        st_d.asf1  = asf_sel;
        // stage 2: phase offset added to the accumulator top bits
        st_d.phase = st_q.acc[F_W-1 -: P_W] + st_q.pow1;
        st_d.asf2  = st_q.asf1;
        // stage 3: sine evaluation
        st_d.sine  = sine_val;
        st_d.asf3  = st_q.asf2;
        // stage 4: amplitude scaling
        prod       = PROD_W'($signed(st_q.sine)) * $signed({1'b0, st_q.asf3});
        st_d.out   = S_W'(prod >>> A_W);
        st_d.alive = (st_q.alive == ALIVE_MAX) ? st_q.alive : st_q.alive + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dac_word = $signed(st_q.out);

    // R4
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ftw_sel == '0) |=> $stable(st_q.acc));

    // R10
    amp_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.alive == ALIVE_MAX && $past(asf_sel, 4) == '0) |-> (dac_word == '0));

    // R6
    sine_range_chk: assert property (@(posedge clk) disable iff (rst)
        (sine_val != {1'b1, {(S_W-1){1'b0}}}));

endmodule

// File: tb/sim_dds_core.sv
module sim_dds_core;

    localparam int NP = 16;
    localparam real PI = 3.14159265358979;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] prof = '0;
    logic [1:0] mode = '0;
    logic [31:0] ftw_w [NP];
    logic [13:0] pow_w [NP];
    logic [9:0]  asf_w [NP];
    logic [NP*32-1:0] ftw_bank;
    logic [NP*14-1:0] pow_bank;
    logic [NP*10-1:0] asf_bank;
    logic signed [9:0] dac;
    logic sclk;

    int checks = 0;
    int errors = 0;
    logic chk_en = 1'b0;
    string cur_req = "R6";

    always #10 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NP; k++) begin
            ftw_bank[k*32 +: 32] = ftw_w[k];
            pow_bank[k*14 +: 14] = pow_w[k];
            asf_bank[k*10 +: 10] = asf_w[k];
        end
    end

    dds_core u0 (
        .clk         (clk),
        .rst         (rst),
        .profile_sel (prof),
        .mod_mode    (mode),
        .ftw_bank    (ftw_bank),
        .pow_bank    (pow_bank),
        .asf_bank    (asf_bank),
        .dac_word    (dac),
        .sync_clk    (sclk)
    );

    function automatic logic [3:0] pick(input logic [1:0] md, input logic [3:0] idx,
                                        input logic [1:0] which);
        return (md == which) ? idx : 4'd0;
    endfunction

    function automatic real ideal(input logic [13:0] ph, input logic [9:0] a);
        return 511.0 * $sin(2.0 * PI * $itor(ph) / 16384.0) * $itor(a) / 1024.0;
    endfunction

    // cycle model built from the requirements
    logic [1:0]  m_cnt;
    logic [3:0]  m_idx;
    logic [1:0]  m_mode;
    logic [31:0] m_acc;
    logic [13:0] m_pow1, m_phase, m_sph;
    logic [9:0]  m_asf1, m_asf2, m_asf3;
    real         m_exp;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 0; m_idx <= 0; m_mode <= 0; m_acc <= 0;
            m_pow1 <= 0; m_phase <= 0; m_sph <= 0;
            m_asf1 <= 0; m_asf2 <= 0; m_asf3 <= 0; m_exp <= 0.0;
        end else begin
            m_cnt <= m_cnt + 2'd1;
            if (m_cnt == 2'd3) begin
                m_idx  <= prof;
                m_mode <= mode;
            end
            m_acc   <= m_acc + ftw_w[pick(m_mode, m_idx, 2'd1)];
            m_pow1  <= pow_w[pick(m_mode, m_idx, 2'd2)];
            m_asf1  <= asf_w[pick(m_mode, m_idx, 2'd3)];
            m_phase <= m_acc[31:18] + m_pow1;
            m_asf2  <= m_asf1;
            m_sph   <= m_phase;
            m_asf3  <= m_asf2;
            m_exp   <= ideal(m_sph, m_asf3);
        end
    end

    task automatic fail(input string req, input string what, input int act, input int exp);
        errors++;
        $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    endtask

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) fail(req, what, act, exp);
    endtask

    // continuous comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (chk_en && !rst) begin
            checks++;
            if (sclk !== (m_cnt < 2'd2))
                fail("R2", "sync_clk", int'(sclk), int'(m_cnt < 2'd2));
            checks++;
            if ($isunknown(dac) || ($itor(dac) - m_exp > 3.0) || (m_exp - $itor(dac) > 3.0))
                fail(cur_req, "dac_word", int'(dac), $rtoi(m_exp));
        end
    end

    task automatic do_reset();
        @(negedge clk);
        chk_en = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_en = 1'b1;
    endtask

    task automatic run_random(input string tag, input logic [1:0] md, input int cycles);
        cur_req = tag;
        for (int k = 0; k < NP; k++) begin
            ftw_w[k] = $urandom;
            pow_w[k] = 14'($urandom);
            asf_w[k] = 10'($urandom);
        end
        mode = md;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if ($urandom_range(2) == 0) prof = 4'($urandom);
        end
    endtask

    task automatic latency_case(input string tag, input logic [1:0] md);
        int seen;
        prof = 4'd0;
        mode = md;
        do_reset();
        cur_req = tag;
        repeat (12) @(negedge clk);
        check_eq(tag, "steady before change", int'(dac), 0);
        prof = 4'd5;
        seen = 0;
        while (sclk) @(negedge clk);
        while (!sclk) @(negedge clk);
        // this falling edge follows the capture edge
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k < 4) check_eq(tag, "R8 output before latency", int'(dac), 0);
            else       check_eq(tag, "R8 output at latency 4", int'(dac), 510);
        end
    endtask

    initial begin
        void'($urandom(32'd1357911));
        for (int k = 0; k < NP; k++) begin
            ftw_w[k] = '0; pow_w[k] = '0; asf_w[k] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check_eq("R1", "dac during reset", int'(dac), 0);
        check_eq("R1", "sync_clk during reset", int'(sclk), 1);
        @(negedge clk);
        rst = 1'b0;
        chk_en = 1'b1;

        run_random("R7 R3", 2'b00, 800);
        run_random("R4 R9 R3", 2'b01, 1500);
        run_random("R5 R9 R3", 2'b10, 1500);
        run_random("R6 R9 R3", 2'b11, 1500);

        // R10: every amplitude slot zero
        cur_req = "R10";
        for (int k = 0; k < NP; k++) asf_w[k] = '0;
        repeat (8) @(negedge clk);
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if ($urandom_range(1) == 0) prof = 4'($urandom);
            check_eq("R10", "zero amplitude output", int'(dac), 0);
        end

        // R8 frequency: slot 5 advances a quarter turn per cycle
        for (int k = 0; k < NP; k++) begin
            ftw_w[k] = '0; pow_w[k] = '0; asf_w[k] = 10'd1023;
        end
        ftw_w[5] = 32'h4000_0000;
        latency_case("R8 freq", 2'b01);

        // R8 phase: slot 5 offsets a quarter turn
        for (int k = 0; k < NP; k++) begin
            ftw_w[k] = '0; pow_w[k] = '0; asf_w[k] = 10'd1023;
        end
        pow_w[5] = 14'd4096;
        latency_case("R8 phase", 2'b10);

        // R8 amplitude: slot 0 silent, slot 5 full scale
        for (int k = 0; k < NP; k++) begin
            ftw_w[k] = '0; pow_w[k] = 14'd4096; asf_w[k] = '0;
        end
        asf_w[5] = 10'd1023;
        latency_case("R8 amp R10", 2'b11);

        @(negedge clk);
        chk_en = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule